// File: doc/BRIEF.md
# System Clock Source Selector

This block picks which of three free-running oscillators drives the chip's main clock. The choices are the primary clock, a slow secondary oscillator and the internal oscillator block. A 2-bit select input names the wanted source. A control state machine runs on its own reference clock, `clk_ctl`, and moves between sources with a request and acknowledge handshake. Each source has a gate cell in its own clock domain. That cell brings the request in through a two-flop synchronizer and opens or closes the gate on the falling edge of its clock. The state machine does not open the new gate until the old gate is seen closed, so no shortened pulse can reach `sys_clk`.

Three status outputs tell software which source is driving the clock. A request for the secondary source is held back while the secondary oscillator enable is low: the block keeps running from the source it already has, and it switches once the enable rises. Start-up timing, oscillator stability and sleep sequencing are handled elsewhere and reach this block only as ready inputs.

The state machine has three states. `ST_WAIT_ON` asks one gate to open and waits for it to report open; its transition `open_done` leads to `ST_RUN`. `ST_RUN` holds the active source and compares it with the source the select input now asks for; its transition `switch_req` leads to `ST_WAIT_OFF` and clears the active source. `ST_WAIT_OFF` waits for the old gate to report closed; its transition `close_done` leads back to `ST_WAIT_ON` for the new source. Reset enters `ST_WAIT_ON` with the primary clock as the target.

Top module: `sysclk_select`

## Requirements
- R1: The select input maps 00 to the primary clock, 01 to the secondary clock and both 10 and 11 to the internal clock. Once the switch has settled, `sys_clk` has the period of the chosen source.
- R2: While `rst_n` is low, `sys_clk` stays low and all three flags are clear. After reset is released, the primary clock is the first source to drive `sys_clk`, whatever the select input says.
- R3: A change on the select input does not act in the same `clk_ctl` cycle. At the next `clk_ctl` edge all flags go clear, and they stay clear while the old gate closes and the new gate opens.
- R4: Select 01 with `sec_en` low leaves the current source and its flags unchanged. When `sec_en` later rises, the block switches to the secondary clock.
- R5: At most one gate is open at any time. Every high and low pulse on `sys_clk` is at least as long as the shortest half-period of the sources taking part.
- R6: `flag_pri` is high exactly when the primary clock drives `sys_clk` and `pri_ready` is high.
- R7: `flag_sec` is high exactly when the secondary clock drives `sys_clk`.
- R8: `flag_int` is high when the internal clock drives `sys_clk`, `int_ready` is high and `int_hf` is high.
- R9: With select 00, `pri_is_hfint` high, and `int_ready` and `int_hf` both high, `flag_pri` and `flag_int` are both set while the primary clock drives `sys_clk`.
- R10: While the select input is not 00, no more than one of the three flags is high.
- R11: All flags are clear while the internal clock drives `sys_clk` and either `int_hf` is low (the low-frequency oscillator) or `int_ready` is low (the high-frequency oscillator is not yet stable).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ctl | input | 1 | Reference clock for the control state machine |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_pri | input | 1 | Primary clock source |
| clk_sec | input | 1 | Secondary low-frequency oscillator |
| clk_int | input | 1 | Internal oscillator block output |
| sel | input | 2 | Source select: 00 primary, 01 secondary, 1x internal |
| sec_en | input | 1 | Secondary oscillator enable |
| pri_ready | input | 1 | Start-up timer of the primary clock has expired |
| int_ready | input | 1 | Internal high-frequency oscillator is stable |
| int_hf | input | 1 | Internal block is in high-frequency mode (low means the low-frequency oscillator) |
| pri_is_hfint | input | 1 | Primary clock is configured as the internal high-frequency oscillator |
| sys_clk | output | 1 | Selected system clock |
| flag_pri | output | 1 | Primary clock is running the system |
| flag_sec | output | 1 | Secondary clock is running the system |
| flag_int | output | 1 | Internal high-frequency clock is stable and running the system |

## Verification
The hardest case to reach from the ports is a switch that is asked for while the old gate is still closing or the new one is still opening. Such a request must neither open two gates nor cut a pulse short. The bench runs the three oscillators at unrelated periods, so each switch begins at a different phase. It walks a table that covers every ordered pair of sources, and it measures the shortest high and low pulse on `sys_clk` across each switch. Reset is released with the internal source already selected, so the brief pass through the primary clock shows up only as a short pulse on `flag_pri`; the bench catches that pulse with an edge-triggered latch.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
package clksel_pkg;

    // Number of clock sources handled by the selector.
    localparam int NUM_SRC = 3;

    // Source codes. The index of each real source is the bit position of
    // its gate in the request and acknowledge vectors.
    typedef enum logic [1:0] {
        SRC_PRI  = 2'd0,
        SRC_SEC  = 2'd1,
        SRC_INT  = 2'd2,
        SRC_NONE = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        ST_WAIT_ON  = 2'd0,
        ST_RUN      = 2'd1,
        ST_WAIT_OFF = 2'd2
    } state_e;

    // Wanted source for a select value. A secondary request with the
    // oscillator disabled keeps the current source.
    function automatic src_e decode_sel(input logic [1:0] sel,
                                        input logic       sec_en,
                                        input src_e       cur);
        src_e res;
        unique case (sel)
            2'b00:   res = SRC_PRI;
            2'b01:   res = sec_en ? SRC_SEC : cur;
            default: res = SRC_INT;
        endcase
        return res;
    endfunction

    // One-hot gate mask for a source code; SRC_NONE gives zero.
    function automatic logic [NUM_SRC-1:0] src_mask(input src_e s);
        logic [NUM_SRC-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (int'(s) == i) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/clksel_sync.sv
`timescale 1ns/1ps
module clksel_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/clksel_gate_cell.sv
`timescale 1ns/1ps
module clksel_gate_cell #(
    parameter int STAGES = 2
) (
    input  logic src_clk,
    input  logic rst_n,
    input  logic en_req,
    output logic clk_out,
    output logic gate_on
);

    logic en_sync;

    // Bring the open request into this source's domain.
    clksel_sync #(
        .STAGES(STAGES),
        .WIDTH (1)
    ) u_req_sync (
        .clk  (src_clk),
        .rst_n(rst_n),
        .d    (en_req),
        .q    (en_sync)
    );

    // The gate changes only while the source clock is low, so an open or a
    // close never trims a high phase.
    always_ff @(negedge src_clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_on <= 1'b0;
        end else begin
            gate_on <= en_sync;
        end
    end

    assign clk_out = src_clk & gate_on;

endmodule

// File: rtl/clksel_ctrl.sv
`timescale 1ns/1ps
module clksel_ctrl
    import clksel_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         sel,
    input  logic               sec_en,
    input  logic               pri_ready,
    input  logic               int_ready,
    input  logic               int_hf,
    input  logic               pri_is_hfint,
    input  logic [NUM_SRC-1:0] ack,
    output logic [NUM_SRC-1:0] en_req,
    output logic               flag_pri,
    output logic               flag_sec,
    output logic               flag_int
);

    state_e st_q, st_d;
    src_e   tgt_q, tgt_d;
    src_e   act_q, act_d;
    src_e   old_q, old_d;
    src_e   want;
    logic   old_ack;
    logic   tgt_ack;
    logic   hf_ok;

    assign want    = decode_sel(sel, sec_en, act_q);
    assign old_ack = |(ack & src_mask(old_q));
    assign tgt_ack = |(ack & src_mask(tgt_q));

    // Next state and transitions.
    always_comb begin
        st_d  = st_q;
        tgt_d = tgt_q;
        act_d = act_q;
        old_d = old_q;
        unique case (st_q)
            ST_WAIT_ON: begin
                if (tgt_ack) begin           // open_done
                    st_d  = ST_RUN;
                    act_d = tgt_q;
                end
            end
            ST_RUN: begin
                if (want != act_q) begin     // switch_req
                    st_d  = ST_WAIT_OFF;
                    old_d = act_q;
                    tgt_d = want;
                    act_d = SRC_NONE;
                end
            end
            ST_WAIT_OFF: begin
                if (!old_ack) begin          // close_done
                    st_d = ST_WAIT_ON;
                end
            end
            default: begin
                st_d = ST_WAIT_ON;
            end
        endcase
    end

    // State register; reset always targets the primary clock first.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_WAIT_ON;
            tgt_q <= SRC_PRI;
            act_q <= SRC_NONE;
            old_q <= SRC_PRI;
        end else begin
            st_q  <= st_d;
            tgt_q <= tgt_d;
            act_q <= act_d;
            old_q <= old_d;
        end
    end

    // Outputs: gate requests and status flags.
    assign hf_ok = int_ready & int_hf;

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            en_req[i] = (st_q != ST_WAIT_OFF) && (int'(tgt_q) == i);
        end
        flag_pri = (act_q == SRC_PRI) && pri_ready;
        flag_sec = (act_q == SRC_SEC);
        flag_int = hf_ok && ((act_q == SRC_INT) ||
                             ((act_q == SRC_PRI) && pri_is_hfint && (sel == 2'b00)));
    end

    // R3: the active source never jumps straight to another one.
    a_r3_no_direct_hop: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN) |=> ((st_q == ST_RUN) && $stable(act_q)) || (act_q == SRC_NONE));

    // R4: a secondary request without the enable leaves the source alone.
    a_r4_sec_deferred: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && sel == 2'b01 && !sec_en) |=> (st_q == ST_RUN) && $stable(act_q));

    // R5: while a gate is opening, every other gate is already reported closed.
    a_r5_others_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT_ON) |-> ((ack & ~src_mask(tgt_q)) == '0));

    // R2: the first gate opened after reset is the primary one.
    a_r2_first_primary: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT_ON && old_q == SRC_PRI && tgt_q == SRC_PRI) |-> (ack[2:1] == 2'b00));

endmodule

// File: rtl/sysclk_select.sv
`timescale 1ns/1ps
module sysclk_select
    import clksel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_ctl,
    input  logic       rst_n,
    input  logic       clk_pri,
    input  logic       clk_sec,
    input  logic       clk_int,
    input  logic [1:0] sel,
    input  logic       sec_en,
    input  logic       pri_ready,
    input  logic       int_ready,
    input  logic       int_hf,
    input  logic       pri_is_hfint,
    output logic       sys_clk,
    output logic       flag_pri,
    output logic       flag_sec,
    output logic       flag_int
);

    logic [NUM_SRC-1:0] src_clk;
    logic [NUM_SRC-1:0] gated;
    logic [NUM_SRC-1:0] gate_on;
    logic [NUM_SRC-1:0] ack;
    logic [NUM_SRC-1:0] en_req;

    assign src_clk[SRC_PRI] = clk_pri;
    assign src_clk[SRC_SEC] = clk_sec;
    assign src_clk[SRC_INT] = clk_int;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        clksel_gate_cell #(
            .STAGES(SYNC_STAGES)
        ) u_cell (
            .src_clk(src_clk[g]),
            .rst_n  (rst_n),
            .en_req (en_req[g]),
            .clk_out(gated[g]),
            .gate_on(gate_on[g])
        );
    end

    assign sys_clk = |gated;

    // Gate states back into the control domain.
    clksel_sync #(
        .STAGES(SYNC_STAGES),
        .WIDTH (NUM_SRC)
    ) u_ack_sync (
        .clk  (clk_ctl),
        .rst_n(rst_n),
        .d    (gate_on),
        .q    (ack)
    );

    clksel_ctrl u_ctrl (
        .clk         (clk_ctl),
        .rst_n       (rst_n),
        .sel         (sel),
        .sec_en      (sec_en),
        .pri_ready   (pri_ready),
        .int_ready   (int_ready),
        .int_hf      (int_hf),
        .pri_is_hfint(pri_is_hfint),
        .ack         (ack),
        .en_req      (en_req),
        .flag_pri    (flag_pri),
        .flag_sec    (flag_sec),
        .flag_int    (flag_int)
    );

    // R5: no two source gates are open together.
    a_r5_one_gate_open: assert property (@(posedge clk_ctl) disable iff (!rst_n)
        $onehot0(gate_on));

    // R10: a non-primary select never shows more than one flag.
    a_r10_single_flag: assert property (@(posedge clk_ctl) disable iff (!rst_n)
        (sel != 2'b00) |-> ($countones({flag_pri, flag_sec, flag_int}) <= 1));

endmodule

// File: tb/tb_sysclk_select.sv
`timescale 1ns/1ps
module tb_sysclk_select;

    logic       clk_ctl = 1'b0;
    logic       clk_pri = 1'b0;
    logic       clk_sec = 1'b0;
    logic       clk_int = 1'b0;
    logic       rst_n   = 1'b0;
    logic [1:0] sel     = 2'b10;
    logic       sec_en  = 1'b0;
    logic       pri_ready    = 1'b1;
    logic       int_ready    = 1'b1;
    logic       int_hf       = 1'b1;
    logic       pri_is_hfint = 1'b0;
    logic       sys_clk, flag_pri, flag_sec, flag_int;

    always #5  clk_ctl = ~clk_ctl;   // 100 MHz
    always #20 clk_pri = ~clk_pri;   // 40 ns
    always #65 clk_sec = ~clk_sec;   // 130 ns
    always #8  clk_int = ~clk_int;   // 16 ns

    sysclk_select dut (
        .clk_ctl(clk_ctl), .rst_n(rst_n),
        .clk_pri(clk_pri), .clk_sec(clk_sec), .clk_int(clk_int),
        .sel(sel), .sec_en(sec_en), .pri_ready(pri_ready),
        .int_ready(int_ready), .int_hf(int_hf), .pri_is_hfint(pri_is_hfint),
        .sys_clk(sys_clk), .flag_pri(flag_pri), .flag_sec(flag_sec), .flag_int(flag_int)
    );

    int n_checks = 0;
    int n_errors = 0;

    // Flags in the order {pri, sec, int}; period in ns.
    typedef struct packed {
        logic [1:0] sel;
        logic       sec_en;
        logic [2:0] flags;
        logic [7:0] period;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 1'b0, 3'b100, 8'd40},
        '{2'b10, 1'b0, 3'b001, 8'd16},
        '{2'b01, 1'b1, 3'b010, 8'd130},
        '{2'b11, 1'b1, 3'b001, 8'd16},
        '{2'b00, 1'b1, 3'b100, 8'd40},
        '{2'b01, 1'b1, 3'b010, 8'd130},
        '{2'b10, 1'b1, 3'b001, 8'd16},
        '{2'b01, 1'b0, 3'b001, 8'd16},
        '{2'b01, 1'b1, 3'b010, 8'd130},
        '{2'b00, 1'b1, 3'b100, 8'd40}
    };

    // Pulse-width monitor on sys_clk.
    real  last_edge = 0.0;
    real  min_w     = 1.0e9;
    logic mon_en    = 1'b0;
    always @(sys_clk) begin
        if (mon_en && last_edge > 0.0 && ($realtime - last_edge) < min_w)
            min_w = $realtime - last_edge;
        last_edge = $realtime;
    end

    // Multiple-flag monitor while the select is not 00.
    int multi_flag = 0;
    always @(negedge clk_ctl) begin
        if (rst_n && sel != 2'b00 && $countones({flag_pri, flag_sec, flag_int}) > 1)
            multi_flag++;
    end

    logic seen_pri = 1'b0;
    always @(posedge flag_pri) seen_pri = 1'b1;

    task automatic check(input string req, input bit ok, input string act, input string exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %s expected %s", req, act, exp);
        end
    endtask

    task automatic check_flags(input string req, input logic [2:0] exp);
        logic [2:0] act;
        act = {flag_pri, flag_sec, flag_int};
        check(req, act === exp, $sformatf("%b", act), $sformatf("%b", exp));
    endtask

    task automatic settle();
        repeat (150) @(negedge clk_ctl);
    endtask

    task automatic measure_period(output real p);
        real t0;
        @(posedge sys_clk);
        t0 = $realtime;
        @(posedge sys_clk);
        p = $realtime - t0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: run hung (R1 switch never completed)");
        finish_run();
    end

    initial begin
        real p;
        bit  stayed_low;

        // R2: reset holds the clock low and the flags clear.
        stayed_low = 1'b1;
        repeat (12) begin
            #7;
            if (sys_clk !== 1'b0) stayed_low = 1'b0;
        end
        check("R2 clock low in reset", stayed_low, "pulse", "low");
        check_flags("R2 flags in reset", 3'b000);

        // Release reset with the internal source selected.
        @(negedge clk_ctl);
        rst_n  = 1'b1;
        mon_en = 1'b1;
        settle();
        check("R2 primary first after reset", seen_pri, "not seen", "seen");
        measure_period(p);
        @(negedge clk_ctl);
        check("R1 internal after reset", p > 15.5 && p < 16.5,
              $sformatf("%0.1f", p), "16.0");
        check_flags("R8 internal after reset", 3'b001);

        // Table of source pairs.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk_ctl);
            sel    = VECS[i].sel;
            sec_en = VECS[i].sec_en;
            min_w  = 1.0e9;
            settle();
            measure_period(p);
            @(negedge clk_ctl);
            check_flags($sformatf("R1/R4/R6/R7/R8 row %0d flags", i), VECS[i].flags);
            check($sformatf("R1 row %0d period", i),
                  p > real'(VECS[i].period) - 0.5 && p < real'(VECS[i].period) + 0.5,
                  $sformatf("%0.1f", p), $sformatf("%0d", VECS[i].period));
            check($sformatf("R5 row %0d min pulse", i), min_w >= 7.9,
                  $sformatf("%0.2f", min_w), ">=8.0");
        end

        // R3: no effect in the same cycle; flags clear during the hand-over.
        @(negedge clk_ctl);
        check_flags("R3 before change", 3'b100);
        sel = 2'b10;
        #1;
        check_flags("R3 same cycle", 3'b100);
        @(negedge clk_ctl);
        check_flags("R3 flags clear in switch", 3'b000);
        settle();
        check_flags("R8 internal running", 3'b001);

        // R11: low-frequency or unstable internal clock gives no flags.
        int_hf = 1'b0;
        @(negedge clk_ctl);
        check_flags("R11 low-frequency internal", 3'b000);
        int_hf    = 1'b1;
        int_ready = 1'b0;
        @(negedge clk_ctl);
        check_flags("R11 internal not stable", 3'b000);
        int_ready = 1'b1;
        @(negedge clk_ctl);
        check_flags("R8 internal stable again", 3'b001);

        // R9: primary configured as the internal clock shows two flags.
        pri_is_hfint = 1'b1;
        sel = 2'b00;
        settle();
        check_flags("R9 double flag", 3'b101);
        pri_ready = 1'b0;
        @(negedge clk_ctl);
        check_flags("R6 primary not ready", 3'b001);
        pri_ready = 1'b1;

        // R4 with R10: deferred secondary request keeps the primary clock.
        sec_en = 1'b0;
        sel = 2'b01;
        settle();
        check_flags("R4/R10 deferred on primary", 3'b100);
        measure_period(p);
        check("R4 still primary period", p > 39.5 && p < 40.5,
              $sformatf("%0.1f", p), "40.0");
        @(negedge clk_ctl);
        sec_en = 1'b1;
        settle();
        check_flags("R4/R7 secondary after enable", 3'b010);

        check("R10 single flag monitor", multi_flag == 0,
              $sformatf("%0d", multi_flag), "0");

        finish_run();
    end

endmodule